// File: doc/BRIEF.md
# Mixed-Decay PWM Chopper Controller

This block performs constant-current chopping for a single H-bridge. It is stepped by a tick derived from an oscillator and divides time into chopper periods of a fixed number of ticks. Each period opens in charge, where current builds in the winding, and charge is held until a digitized sense-current comparator reports that the set level has been reached. The bridge then recirculates in slow decay. The closing part of every period is always spent in fast decay, which returns winding energy to the supply. A comparator edge that arrives while the switching spike at the start of charge is still present is hidden by a blanking window.

The four gate controls (upper and lower switch on side A and on side B) follow the commanded current polarity. A zero-magnitude command or a low enable turns all four switches off, which puts the bridge in high impedance. Any change from one driven switch pattern to a different one passes through one tick with every switch off, so that the two switches on one side never conduct together. All inputs are level-sampled control pins. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `mixed_decay_chopper`

## Requirements
- R1: A chopper period is 16 ticks. Position p (0..15) names the tick interval after the p-th tick edge of a period. Out of reset the gates are all off, and the first tick starts position 0.
- R2: While charging with blanking expired, a high comparator flag sampled at a tick ends charge. Slow decay follows (after one dead tick) and lasts until the fast window.
- R3: After each entry into charge, the comparator flag is ignored at the first BLANK ticks (default 1). With the flag held high, charge therefore lasts BLANK+1 tick intervals.
- R4: Positions 10 to 15 (the last 6 ticks) are requested as fast decay whether or not the comparator has tripped. With no trip, charge runs up to position 9.
- R5: With polarity input 0, charge drives hs_a and ls_b, slow decay drives ls_a and ls_b, and fast decay drives hs_b and ls_a.
- R6: With polarity input 1, charge drives hs_b and ls_a, slow decay drives ls_a and ls_b, and fast decay drives hs_a and ls_b.
- R7: When mag_zero is high or drive_en is low at a tick, all four gates are off from that tick on, with no dead tick.
- R8: hs_a and ls_a are never high together, and neither are hs_b and ls_b.
- R9: A change between two different driven patterns, including a change caused by a polarity change, inserts exactly one tick interval with all gates off. The target state is then applied at the next tick.
- R10: The gates change only at a clock edge at which osc_tick is high, and they are valid right after that edge.
- R11: A trip latched in one period is cleared at position 0, so every period begins with a request for charge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-clock pulse per oscillator cycle |
| sense_trip | input | 1 | Comparator flag: winding current at or above the set level |
| dir_rev | input | 1 | Commanded polarity: 0 forward, 1 reverse |
| mag_zero | input | 1 | Commanded current magnitude is zero |
| drive_en | input | 1 | Bridge enable |
| hs_a | output | 1 | Upper switch, side A |
| ls_a | output | 1 | Lower switch, side A |
| hs_b | output | 1 | Upper switch, side B |
| ls_b | output | 1 | Lower switch, side B |

## Verification
Every result of this block is due at the clock edge that carries a tick. The period position, the trip latch, the blanking count and the bridge state all move at that edge, and the gates, decoded from those registers, are settled before the following falling edge. The bench drives its inputs on falling edges and updates a behavioural model at the same rising edges as the design. It compares all four gates on every falling edge, so a result that comes one tick early or late, or that changes between ticks, shows up as a mismatch. Trip timing is set relative to the model's period position, which places trips inside, at the edge of and after the blanking window.

// File: rtl/chop_pkg.sv
package chop_pkg;

  typedef enum logic [1:0] {
    BR_OFF    = 2'd0,
    BR_CHARGE = 2'd1,
    BR_SLOW   = 2'd2,
    BR_FAST   = 2'd3
  } bridge_e;

  // gate order: {hs_a, ls_a, hs_b, ls_b}
  typedef logic [3:0] gate_t;

  function automatic gate_t bridge_gates(bridge_e st, logic rev);
    gate_t g;
    case (st)
      BR_CHARGE: g = rev ? 4'b0110 : 4'b1001;
      BR_SLOW:   g = 4'b0101;
      BR_FAST:   g = rev ? 4'b1001 : 4'b0110;
      default:   g = 4'b0000;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/chop_period_timer.sv
module chop_period_timer #(
  parameter int PERIOD     = 16,
  parameter int FAST_TICKS = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic wrap_next,
  output logic fast_next
);
  localparam int POS_W      = $clog2(PERIOD);
  localparam int FAST_START = PERIOD - FAST_TICKS;

  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] pos_n;

  always_comb begin
    pos_n     = (pos_q == POS_W'(PERIOD - 1)) ? '0 : pos_q + 1'b1;
    wrap_next = (pos_n == '0);
    fast_next = (pos_n >= POS_W'(FAST_START));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pos_q <= POS_W'(PERIOD - 1);
    else if (tick) pos_q <= pos_n;
  end
endmodule

// File: rtl/chop_trip_gate.sv
module chop_trip_gate
  import chop_pkg::*;
#(
  parameter int BLANK = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    trip,
  input  logic    wrap_next,
  input  bridge_e cur,
  input  bridge_e cur_next,
  output logic    latched_next
);
  localparam int BLK_W = (BLANK < 1) ? 1 : $clog2(BLANK + 1);

  logic [BLK_W-1:0] blk_q;
  logic             trip_q;
  logic             accept;

  always_comb begin
    accept       = (cur == BR_CHARGE) && (blk_q == '0) && trip;
    latched_next = wrap_next ? 1'b0 : (trip_q | accept);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q  <= '0;
      trip_q <= 1'b0;
    end else if (tick) begin
      trip_q <= latched_next;
      if (cur_next == BR_CHARGE && cur != BR_CHARGE)
        blk_q <= BLK_W'(BLANK);
      else if (cur == BR_CHARGE && blk_q != '0)
        blk_q <= blk_q - 1'b1;
    end
  end
endmodule

// File: rtl/chop_sequencer.sv
module chop_sequencer
  import chop_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tick,
  input  logic    drive_en,
  input  logic    mag_zero,
  input  logic    dir_rev,
  input  logic    fast_next,
  input  logic    latched_next,
  output bridge_e cur,
  output logic    cur_rev,
  output bridge_e cur_next
);
  bridge_e want;
  logic    needs_dead;

  always_comb begin
    if (!drive_en || mag_zero) want = BR_OFF;
    else if (fast_next)        want = BR_FAST;
    else if (latched_next)     want = BR_SLOW;
    else                       want = BR_CHARGE;
    needs_dead = (cur != BR_OFF) && (want != BR_OFF) &&
                 ((want != cur) || (dir_rev != cur_rev));
    cur_next   = needs_dead ? BR_OFF : want;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur     <= BR_OFF;
      cur_rev <= 1'b0;
    end else if (tick) begin
      cur     <= cur_next;
      cur_rev <= dir_rev;
    end
  end
endmodule

// File: rtl/chop_gate_drive.sv
module chop_gate_drive
  import chop_pkg::*;
(
  input  bridge_e cur,
  input  logic    cur_rev,
  output logic    hs_a,
  output logic    ls_a,
  output logic    hs_b,
  output logic    ls_b
);
  gate_t g;
  always_comb begin
    g = bridge_gates(cur, cur_rev);
    {hs_a, ls_a, hs_b, ls_b} = g;
  end
endmodule

// File: rtl/mixed_decay_chopper.sv
module mixed_decay_chopper
  import chop_pkg::*;
#(
  parameter int PERIOD     = 16,
  parameter int FAST_TICKS = 6,
  parameter int BLANK      = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic sense_trip,
  input  logic dir_rev,
  input  logic mag_zero,
  input  logic drive_en,
  output logic hs_a,
  output logic ls_a,
  output logic hs_b,
  output logic ls_b
);
  logic    wrap_next, fast_next, latched_next, cur_rev;
  bridge_e cur, cur_next;

  chop_period_timer #(.PERIOD(PERIOD), .FAST_TICKS(FAST_TICKS)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick),
    .wrap_next(wrap_next), .fast_next(fast_next)
  );

  chop_trip_gate #(.BLANK(BLANK)) u_trip (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick), .trip(sense_trip),
    .wrap_next(wrap_next), .cur(cur), .cur_next(cur_next),
    .latched_next(latched_next)
  );

  chop_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .tick(osc_tick),
    .drive_en(drive_en), .mag_zero(mag_zero), .dir_rev(dir_rev),
    .fast_next(fast_next), .latched_next(latched_next),
    .cur(cur), .cur_rev(cur_rev), .cur_next(cur_next)
  );

  chop_gate_drive u_drv (
    .cur(cur), .cur_rev(cur_rev),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );
endmodule

// File: rtl/mixed_decay_chopper_chk.sv
module mixed_decay_chopper_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_tick,
  input logic mag_zero,
  input logic drive_en,
  input logic hs_a,
  input logic ls_a,
  input logic hs_b,
  input logic ls_b
);
  logic [3:0] g, prev_g;
  logic       prev_v, prev_tick, prev_idle;

  assign g = {hs_a, ls_a, hs_b, ls_b};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_v    <= 1'b0;
      prev_g    <= 4'b0;
      prev_tick <= 1'b0;
      prev_idle <= 1'b0;
    end else begin
      prev_v    <= 1'b1;
      prev_g    <= g;
      prev_tick <= osc_tick;
      prev_idle <= osc_tick && (mag_zero || !drive_en);
    end
  end

  a_r8_no_overlap_a: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_a && ls_a));
  a_r8_no_overlap_b: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_b && ls_b));
  a_r9_dead_between: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_v && prev_g != 4'b0 && g != 4'b0) |-> (g == prev_g));
  a_r7_off_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_v && prev_idle) |-> (g == 4'b0));
  a_r10_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_v && !prev_tick) |-> (g == prev_g));
endmodule

bind mixed_decay_chopper mixed_decay_chopper_chk u_chk (.*);

// File: tb/mixed_decay_chopper_tb.sv
`timescale 1ns/1ps
module mixed_decay_chopper_tb;
  localparam int BLANK = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0, sense_trip = 1'b0, dir_rev = 1'b0;
  logic mag_zero = 1'b0, drive_en = 1'b1;
  logic hs_a, ls_a, hs_b, ls_b;

  always #10 clk = ~clk;

  mixed_decay_chopper u_dut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sense_trip(sense_trip),
    .dir_rev(dir_rev), .mag_zero(mag_zero), .drive_en(drive_en),
    .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
  );

  int total = 0, bad = 0;
  bit done = 0, cmp_on = 0;

  // model state: st 0 off, 1 charge, 2 slow, 3 fast
  int mpos, mst, mblk;
  bit mlat, mdir;
  int div = 0;
  bit trip_all = 0;
  int trip_lo = -1;

  always @(posedge clk) begin
    int np, w, ns;
    bit acc, nl;
    if (!rst_n) begin
      mpos = 15; mst = 0; mblk = 0; mlat = 0; mdir = 0;
    end else if (osc_tick) begin
      np  = (mpos == 15) ? 0 : mpos + 1;
      acc = (mst == 1) && (mblk == 0) && sense_trip;
      nl  = (np == 0) ? 0 : (mlat || acc);
      if (!drive_en || mag_zero) w = 0;
      else if (np >= 10)         w = 3;
      else if (nl)               w = 2;
      else                       w = 1;
      if (mst != 0 && w != 0 && (w != mst || dir_rev != mdir)) ns = 0;
      else ns = w;
      if (ns == 1 && mst != 1) mblk = BLANK;
      else if (mst == 1 && mblk > 0) mblk = mblk - 1;
      mpos = np; mlat = nl; mst = ns; mdir = dir_rev;
    end
  end

  function automatic logic [3:0] expect_g(int st, bit rev);
    case (st)
      1: return rev ? 4'b0110 : 4'b1001;
      2: return 4'b0101;
      3: return rev ? 4'b1001 : 4'b0110;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic string tag_of(int st, bit rev);
    case (st)
      1: return rev ? "R6" : "R5";
      2: return "R2";
      3: return "R4";
      default: return (!drive_en || mag_zero) ? "R7" : "R9";
    endcase
  endfunction

  // compare and drive on falling edges
  always @(negedge clk) begin
    logic [3:0] got, exp;
    if (cmp_on) begin
      got = {hs_a, ls_a, hs_b, ls_b};
      exp = expect_g(mst, mdir);
      total++;
      if (got !== exp) begin
        bad++;
        $display("FAIL %s pos=%0d got=%b exp=%b t=%0t", tag_of(mst, mdir), mpos, got, exp, $time);
      end
      total++;
      if ((hs_a && ls_a) || (hs_b && ls_b)) begin
        bad++;
        $display("FAIL R8 overlap got=%b exp=no same-side pair", got);
      end
    end
    div = (div == 2) ? 0 : div + 1;
    osc_tick <= (div == 2);
    sense_trip <= trip_all || (trip_lo >= 0 && mpos >= trip_lo && mpos < 10);
  end

  task automatic run_ticks(int n);
    repeat (n * 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state, gates off
    total++;
    if ({hs_a, ls_a, hs_b, ls_b} !== 4'b0) begin
      bad++; $display("FAIL R1 reset got=%b exp=0000", {hs_a, ls_a, hs_b, ls_b});
    end
    cmp_on = 1;
    rst_n = 1'b1;
    // R1 R4 R5: no trip, forward, three periods (R10 checked each clock)
    run_ticks(48);
    // R2 R11: trip from position 4, latch must clear each period
    trip_lo = 4; run_ticks(48);
    // R3: flag held high, blanking sets charge length
    trip_lo = -1; trip_all = 1; run_ticks(32);
    trip_all = 0;
    // R6: reverse polarity with trip at position 6
    dir_rev = 1; trip_lo = 6; run_ticks(48);
    // R9: polarity flip during charge
    trip_lo = -1; run_ticks(18); dir_rev = 0; run_ticks(5); dir_rev = 1; run_ticks(25);
    // R7: zero magnitude, then enable low
    mag_zero = 1; run_ticks(20); mag_zero = 0; run_ticks(12);
    drive_en = 0; run_ticks(20); drive_en = 1; trip_lo = 3; run_ticks(32);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule